// File: doc/BRIEF.md
# Floating-Point Conditional Branch Resolver

This block decides the outcome of a floating-point conditional branch. It takes the branch instruction word, the address of the branch itself and the current 2-bit floating-point condition code. From these it works out whether the branch is taken and where it goes. It also decides what happens to the instruction that follows the branch (the delay slot) and which address the pipeline should fetch next.

Each of the 16 branch conditions is a set drawn from four outcomes: equal, less, greater and unordered. The branch is taken when the current condition code is one of the outcomes in that set. The delay-slot rules depend on whether the branch is unconditional. An unconditional branch with the annul bit set skips its delay slot and goes straight to the target. A conditional branch that is taken always runs its delay slot. Any branch that is not taken and has the annul bit set skips its delay slot.

A counter of taken branches is kept and can be read at all times. A branch is presented with a one-cycle `issueValid` strobe. The result is registered and appears one cycle later, marked by `resValid`.

Top module: `fp_branch_resolver`

## Requirements
- R1: The condition code is encoded 0=equal, 1=less, 2=greater, 3=unordered. The condition is taken from instruction bits 28:25. The branch is taken when the code lies in the set for that condition: 1 {L,G,U}, 2 {L,G}, 3 {U,L}, 4 {L}, 5 {U,G}, 6 {G}, 7 {U}, 9 {E}, 10 {U,E}, 11 {G,E}, 12 {U,G,E}, 13 {E,L}, 14 {U,L,E}, 15 {E,L,G}.
- R2: Condition 0 is never taken and condition 8 is always taken, whatever the condition code.
- R3: `target` is `pc` plus instruction bits 21:0, sign-extended from bit 21 and shifted left by 2. The sum wraps modulo 2^ADDR_W.
- R4: A branch that is not taken and has the annul bit (instruction bit 29) set gives `annulSlot`=1 and `nextPc`=pc+8.
- R5: A branch that is not taken and has the annul bit clear gives `annulSlot`=0 and `nextPc`=pc+4.
- R6: Condition 8 with the annul bit set gives `annulSlot`=1 and `nextPc`=target.
- R7: A taken branch that is not the case in R6 gives `annulSlot`=0 and `nextPc`=pc+4. This covers every taken conditional branch, whatever its annul bit, and condition 8 with the annul bit clear.
- R8: `takenCount` is 0 after reset. It rises by exactly one for each taken branch, wraps modulo 2^CNT_W, and is unchanged otherwise.
- R9: The results appear in the cycle after `issueValid`, together with a one-cycle `resValid` pulse. While no branch is issued, the outputs hold their values. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | A branch is presented this cycle |
| instr | input | 32 | Branch instruction word |
| pc | input | ADDR_W | Address of the branch |
| fcc | input | 2 | Floating-point condition code |
| resValid | output | 1 | Results below were updated last cycle |
| taken | output | 1 | Branch is taken |
| annulSlot | output | 1 | Delay-slot instruction is skipped |
| target | output | ADDR_W | Branch target address |
| nextPc | output | ADDR_W | Next address to fetch |
| takenCount | output | CNT_W | Number of taken branches |

## Verification
The assertions assume that `issueValid` marks a complete, stable set of `instr`, `pc` and `fcc` in that cycle. They also assume that `pc` can change freely between issues, because the hold check looks only at the registered outputs. The stimulus drives every input on the falling edge and raises `issueValid` for exactly one cycle per branch. Between branches it changes the inputs to unrelated values, so that a result taken from an idle cycle would show up at the outputs. It sweeps all 16 conditions against all four codes with the annul bit both clear and set, and uses displacements at both signed extremes as well as one that wraps the address.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef enum logic [1:0] {
    FCC_EQ = 2'd0,
    FCC_LT = 2'd1,
    FCC_GT = 2'd2,
    FCC_UN = 2'd3
  } fccT;

  localparam logic [3:0] COND_NEVER  = 4'd0;
  localparam logic [3:0] COND_ALWAYS = 4'd8;

  typedef struct packed {
    logic load;       // capture a new result
    logic taken;      // branch goes to the target
    logic jumpTarget; // skip slot, fetch target directly
    logic skipSlot;   // not taken, skip slot
  } brStrobeT;

  // Outcome set for a condition, bit order {U,G,L,E}
  function automatic logic [3:0] condSet(input logic [3:0] cond);
    logic [3:0] s;
    case (cond)
      4'd0:    s = 4'b0000;
      4'd1:    s = 4'b1110;
      4'd2:    s = 4'b0110;
      4'd3:    s = 4'b1010;
      4'd4:    s = 4'b0010;
      4'd5:    s = 4'b1100;
      4'd6:    s = 4'b0100;
      4'd7:    s = 4'b1000;
      4'd8:    s = 4'b1111;
      4'd9:    s = 4'b0001;
      4'd10:   s = 4'b1001;
      4'd11:   s = 4'b0101;
      4'd12:   s = 4'b1101;
      4'd13:   s = 4'b0011;
      4'd14:   s = 4'b1011;
      default: s = 4'b0111;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issueValid,
  input  logic [3:0] cond,
  input  logic       annulBit,
  input  logic [1:0] fcc,
  output brStrobeT   strobe
);

  logic [3:0] outcomeSet;
  logic       isAlways;
  logic       condMet;

  always_comb begin
    outcomeSet = condSet(cond);
    isAlways   = (cond == COND_ALWAYS);
    condMet    = outcomeSet[fcc];
  end

  always_comb begin
    strobe.load       = issueValid;
    strobe.taken      = issueValid && condMet;
    strobe.jumpTarget = issueValid && isAlways && annulBit;
    strobe.skipSlot   = issueValid && annulBit && !condMet;
  end

  AST_NEVER_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && cond == COND_NEVER) |-> !strobe.taken); // R2
  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && cond == COND_ALWAYS) |-> strobe.taken); // R2
  AST_SLOT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strobe.jumpTarget, strobe.skipSlot}) <= 1); // R6
  AST_STROBE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |-> !(strobe.taken || strobe.jumpTarget || strobe.skipSlot)); // R9

endmodule

// File: rtl/fbr_dp.sv
module fbr_dp
  import fbr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 22,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  brStrobeT          strobe,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic              resValid,
  output logic              taken,
  output logic              annulSlot,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] nextPc,
  output logic [CNT_W-1:0]  takenCount
);

  localparam int EXT_W = ADDR_W - DISP_W - 2;
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(8);

  logic [ADDR_W-1:0] dispByte;
  logic [ADDR_W-1:0] targetNxt;
  logic [ADDR_W-1:0] nextPcNxt;

  always_comb begin
    dispByte  = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
    targetNxt = pc + dispByte;
    if (strobe.jumpTarget)    nextPcNxt = targetNxt;
    else if (strobe.skipSlot) nextPcNxt = pc + STEP2;
    else                      nextPcNxt = pc + STEP1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resValid   <= 1'b0;
      taken      <= 1'b0;
      annulSlot  <= 1'b0;
      target     <= '0;
      nextPc     <= '0;
      takenCount <= '0;
    end else begin
      resValid <= strobe.load;
      if (strobe.load) begin
        taken     <= strobe.taken;
        annulSlot <= strobe.jumpTarget || strobe.skipSlot;
        target    <= targetNxt;
        nextPc    <= nextPcNxt;
      end
      if (strobe.taken) takenCount <= takenCount + 1'b1;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.taken |=> takenCount == $past(takenCount) + 1'b1); // R8
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.taken |=> $stable(takenCount)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> (!resValid && $stable(target) && $stable(nextPc) && $stable(taken))); // R9
  AST_SLOT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && !strobe.jumpTarget && !strobe.skipSlot) |=> (!annulSlot && nextPc == $past(pc) + STEP1)); // R7
  AST_SKIP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.skipSlot |=> (annulSlot && !taken && nextPc == $past(pc) + STEP2)); // R4

endmodule

// File: rtl/fp_branch_resolver.sv
module fp_branch_resolver
  import fbr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issueValid,
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [1:0]        fcc,
  output logic              resValid,
  output logic              taken,
  output logic              annulSlot,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] nextPc,
  output logic [CNT_W-1:0]  takenCount
);

  localparam int DISP_W   = 22;
  localparam int COND_LSB = 25;
  localparam int ANNUL_BIT = 29;

  brStrobeT strobe;
  logic     unusedOpBits;

  assign unusedOpBits = ^{instr[31:30], instr[24:22]};

  fbr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .issueValid (issueValid),
    .cond       (instr[COND_LSB+3:COND_LSB]),
    .annulBit   (instr[ANNUL_BIT]),
    .fcc        (fcc),
    .strobe     (strobe)
  );

  fbr_dp #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .pc         (pc),
    .disp       (instr[DISP_W-1:0]),
    .resValid   (resValid),
    .taken      (taken),
    .annulSlot  (annulSlot),
    .target     (target),
    .nextPc     (nextPc),
    .takenCount (takenCount)
  );

endmodule

// File: tb/tb_fp_branch_resolver.sv
module tb_fp_branch_resolver;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issueValid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic [1:0]  fcc = '0;
  logic        resValid, taken, annulSlot;
  logic [31:0] target, nextPc;
  logic [15:0] takenCount;

  int checks = 0;
  int fails  = 0;
  logic [15:0] expCount = '0;

  always #2 clk = ~clk;

  fp_branch_resolver dut (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .instr(instr),
    .pc(pc), .fcc(fcc), .resValid(resValid), .taken(taken),
    .annulSlot(annulSlot), .target(target), .nextPc(nextPc),
    .takenCount(takenCount)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Encoding: 0=E 1=L 2=G 3=U (R1)
  function automatic logic modelTaken(input logic [3:0] c, input logic [1:0] f);
    logic e, l, g, u;
    e = (f == 2'd0); l = (f == 2'd1); g = (f == 2'd2); u = (f == 2'd3);
    case (c)
      4'd0:  return 1'b0;
      4'd1:  return l | g | u;
      4'd2:  return l | g;
      4'd3:  return u | l;
      4'd4:  return l;
      4'd5:  return u | g;
      4'd6:  return g;
      4'd7:  return u;
      4'd8:  return 1'b1;
      4'd9:  return e;
      4'd10: return u | e;
      4'd11: return g | e;
      4'd12: return u | g | e;
      4'd13: return e | l;
      4'd14: return u | l | e;
      default: return e | l | g;
    endcase
  endfunction

  function automatic logic [31:0] mkInstr(input logic a, input logic [3:0] c, input logic [21:0] d);
    return {2'b00, a, c, 3'b110, d};
  endfunction

  // Issue one branch, check all outputs one cycle later
  task automatic runBranch(input logic a, input logic [3:0] c, input logic [21:0] d,
                           input logic [31:0] p, input logic [1:0] f, input string tag);
    logic        expT, expA;
    logic [31:0] expTgt, expNext;
    expT   = modelTaken(c, f);
    expTgt = p + {{8{d[21]}}, d, 2'b00};
    if (!expT) begin
      expA = a; expNext = a ? p + 32'd8 : p + 32'd4;
    end else if (c == 4'd8 && a) begin
      expA = 1'b1; expNext = expTgt;
    end else begin
      expA = 1'b0; expNext = p + 32'd4;
    end
    if (expT) expCount = expCount + 1'b1;
    @(negedge clk);
    instr = mkInstr(a, c, d); pc = p; fcc = f; issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
    instr = ~instr; pc = ~p; fcc = ~f;
    check({tag, " resValid R9"}, resValid, 1);
    check({tag, " taken R1"}, taken, expT);
    check({tag, " annul R4/R5/R6/R7"}, annulSlot, expA);
    check({tag, " target R3"}, target, expTgt);
    check({tag, " nextPc"}, nextPc, expNext);
    check({tag, " count R8"}, takenCount, expCount);
  endtask

  task automatic testReset();
    check("reset R9 resValid", resValid, 0);
    check("reset R9 taken", taken, 0);
    check("reset R9 annul", annulSlot, 0);
    check("reset R9 target", target, 0);
    check("reset R9 nextPc", nextPc, 0);
    check("reset R8 count", takenCount, 0);
  endtask

  task automatic testConditionTable();
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 4; f++)
        runBranch(1'b0, 4'(c), 22'h10, 32'h0000_4000, 2'(f), "R1 table");
  endtask

  task automatic testNeverAlways();
    for (int f = 0; f < 4; f++) begin
      runBranch(1'b0, 4'd0, 22'h3, 32'h100, 2'(f), "R2 never");
      runBranch(1'b0, 4'd8, 22'h3, 32'h100, 2'(f), "R2 always");
    end
  endtask

  task automatic testAnnulRules();
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 4; f++)
        runBranch(1'b1, 4'(c), 22'h3FFFF0, 32'h0001_0000, 2'(f), "R4 R6 R7 annul");
    runBranch(1'b1, 4'd8, 22'h25, 32'h2000, 2'd1, "R6 always annul");
    runBranch(1'b1, 4'd4, 22'h25, 32'h2000, 2'd1, "R7 taken cond annul");
    runBranch(1'b1, 4'd4, 22'h25, 32'h2000, 2'd2, "R4 not taken annul");
    runBranch(1'b0, 4'd4, 22'h25, 32'h2000, 2'd2, "R5 not taken run");
  endtask

  task automatic testDisplacement();
    runBranch(1'b0, 4'd8, 22'h1FFFFF, 32'h0000_0040, 2'd0, "R3 max pos");
    runBranch(1'b0, 4'd8, 22'h200000, 32'h8000_0000, 2'd0, "R3 max neg");
    runBranch(1'b0, 4'd8, 22'h3FFFFF, 32'h0000_0000, 2'd0, "R3 wrap");
    runBranch(1'b1, 4'd8, 22'h200000, 32'h0000_0004, 2'd3, "R3 R6 neg jump");
  endtask

  task automatic testHold();
    logic [31:0] t0, n0;
    logic [15:0] k0;
    logic        a0, v0;
    runBranch(1'b1, 4'd6, 22'h7, 32'h3000, 2'd2, "R9 setup");
    t0 = target; n0 = nextPc; k0 = takenCount; a0 = annulSlot;
    repeat (3) begin
      @(negedge clk);
      instr = mkInstr(1'b1, 4'd8, 22'h1234); pc = 32'hABCD_0000; fcc = 2'd0;
    end
    v0 = resValid;
    check("R9 hold resValid", v0, 0);
    check("R9 hold target", target, t0);
    check("R9 hold nextPc", nextPc, n0);
    check("R9 hold annul", annulSlot, a0);
    check("R8 hold count", takenCount, k0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    testConditionTable();
    testNeverAlways();
    testAnnulRules();
    testDisplacement();
    testHold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule